// File: doc/BRIEF.md
# Undefined-Length Burst Chunk Predictor

This block watches the address phase of one AHB master's transfers into a slave port. When the master issues an incrementing burst of unspecified length (HBURST = INCR), the block cuts it into virtual fixed-length chunks. It raises a one-cycle end-of-chunk strobe on the beat that closes each chunk. The slave's arbiter can then treat the open-ended burst as a sequence of defined-length bursts and re-arbitrate at each chunk edge instead of waiting for the master to stop.

The chunk length comes from a static 3-bit mode input that selects one of eight settings. One setting is "never split", which is also the value after reset. Another cuts after every beat, and the rest are powers of two from 4 to 128 beats. Fixed-length bursts pass without any strobe. Wait states and BUSY cycles do not advance the count. An IDLE cycle or a fresh NONSEQ starts the count again.

Top module: `incr_chunk_predictor`

## Requirements
- R1: With `beat_mode` = k for k in 2..7, an INCR burst produces a strobe on beats 2^k, 2·2^k, 3·2^k, … counted from its opening NONSEQ (4, 8, 16, 32, 64 or 128 beats per chunk) and on no other beat.
- R2: With `beat_mode` = 0, the unlimited setting, `eob_pred` never rises, however long the INCR burst runs.
- R3: With `beat_mode` = 1, every accepted beat of an INCR burst, the NONSEQ included, raises `eob_pred`.
- R4: A beat counts only in a cycle where `sel` = 1, `hready` = 1 and `htrans` is NONSEQ (2'b10) or SEQ (2'b11). Wait-state cycles and cycles with `sel` = 0 neither count nor strobe.
- R5: A BUSY cycle (`htrans` = 2'b01) neither advances the beat count nor strobes. The burst resumes its chunk count afterwards.
- R6: An accepted IDLE cycle (`htrans` = 2'b00 with `sel` and `hready` high) ends the burst and clears the count. A later INCR burst starts a full new chunk.
- R7: Every accepted NONSEQ restarts the count at its own beat 1, even if it directly follows an unfinished chunk.
- R8: Bursts whose NONSEQ carries any `hburst` value other than INCR (3'b001) produce no strobe on their NONSEQ or SEQ beats, in any mode.
- R9: `eob_pred` is combinational and high in the same cycle as the accepted beat that closes a chunk. The beats after it form a new, independent chunk.
- R10: After reset the count is zero. `eob_pred` is low while the bus is idle, and the first INCR burst strobes first on its N-th beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| beat_mode | input | 3 | Chunk length: 0 unlimited, 1 one beat, k = 2..7 gives 2^k beats |
| sel | input | 1 | Master addresses this slave in the current address phase |
| htrans | input | 2 | AHB transfer type (IDLE, BUSY, NONSEQ, SEQ) |
| hburst | input | 3 | AHB burst type; 3'b001 marks an undefined-length INCR |
| hready | input | 1 | Address phase accepted this cycle |
| eob_pred | output | 1 | Predicted end of burst, high on the closing beat of a chunk |

## Verification
The assertions assume a bus that follows AHB ordering. A burst opens with NONSEQ, SEQ and BUSY appear only inside a burst, and `beat_mode` changes only while no burst is open. The stimulus respects these rules. Every scenario task starts from an accepted IDLE, sets the mode only at that point, and then drives a legal NONSEQ/SEQ/BUSY sequence. Within that sequence it adds wait states, deselected cycles and abrupt restarts, and it checks each cycle against the beat index and the chunk length.

// File: rtl/incr_chunk_predictor.sv
module incr_chunk_predictor #(
  parameter int MODE_W = 3,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] beat_mode,
  input  logic              sel,
  input  logic [1:0]        htrans,
  input  logic [2:0]        hburst,
  input  logic              hready,
  output logic              eob_pred
);

  localparam logic [1:0] T_IDLE   = 2'b00;
  localparam logic [1:0] T_BUSY   = 2'b01;
  localparam logic [1:0] T_NONSEQ = 2'b10;
  localparam logic [2:0] B_INCR   = 3'b001;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim_m1;
  logic [CNT_W-1:0] base;
  logic             in_incr;
  logic             xfer, nonseq, incr_now, idle_acc;

  assign xfer     = sel & hready & htrans[1];
  assign nonseq   = (htrans == T_NONSEQ);
  assign idle_acc = sel & hready & (htrans == T_IDLE);
  assign incr_now = nonseq ? (hburst == B_INCR) : in_incr;
  assign base     = nonseq ? '0 : cnt;

  always_comb begin
    if (beat_mode == MODE_W'(1))
      lim_m1 = '0;
    else
      lim_m1 = CNT_W'((32'd1 << beat_mode) - 32'd1);
  end

  assign eob_pred = xfer & incr_now & (beat_mode != '0) & (base == lim_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      in_incr <= 1'b0;
    end else if (xfer) begin
      in_incr <= incr_now;
      cnt     <= eob_pred ? '0 : base + 1'b1;
    end else if (idle_acc) begin
      in_incr <= 1'b0;
      cnt     <= '0;
    end
  end

  p_quiet_unlim_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_mode == '0) |-> !eob_pred);

  p_every_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_mode == MODE_W'(1) && sel && hready && htrans == T_NONSEQ && hburst == B_INCR) |-> eob_pred);

  p_on_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eob_pred |-> (sel && hready && htrans[1]));

  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && htrans == T_BUSY) |=> $stable(cnt));

  p_idle_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && hready && htrans == T_IDLE) |=> (cnt == '0));

  p_fixed_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == T_NONSEQ && hburst != B_INCR) |-> !eob_pred);

  p_chunk_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eob_pred |=> (cnt == '0));

endmodule

// File: tb/incr_chunk_predictor_tb.sv
module incr_chunk_predictor_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] beat_mode = 3'd0;
  logic       sel = 1'b0;
  logic [1:0] htrans = 2'b00;
  logic [2:0] hburst = 3'b000;
  logic       hready = 1'b1;
  logic       eob_pred;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [1:0] IDL = 2'b00, BSY = 2'b01, NSQ = 2'b10, SQ = 2'b11;
  localparam logic [2:0] INCR = 3'b001, INCR4 = 3'b011;

  always #10 clk = ~clk;

  incr_chunk_predictor u_dut (
    .clk(clk), .rst_n(rst_n), .beat_mode(beat_mode), .sel(sel),
    .htrans(htrans), .hburst(hburst), .hready(hready), .eob_pred(eob_pred)
  );

  task automatic cyc(input logic s, input logic [1:0] t, input logic [2:0] b,
                     input logic r, input logic exp, input string req);
    @(negedge clk);
    sel = s; htrans = t; hburst = b; hready = r;
    #5;
    n_chk++;
    if (eob_pred !== exp) begin
      n_bad++;
      $display("FAIL %s: eob_pred=%0b expected %0b", req, eob_pred, exp);
    end
  endtask

  task automatic go_idle(input logic [2:0] m);
    cyc(1'b1, IDL, 3'b000, 1'b1, 1'b0, "R6");
    beat_mode = m;
  endtask

  task automatic t_reset();
    cyc(1'b1, IDL, 3'b000, 1'b1, 1'b0, "R10");
    cyc(1'b0, IDL, 3'b000, 1'b1, 1'b0, "R10");
  endtask

  task automatic t_chunks(input logic [2:0] m, input int n, input string req);
    int len = 1 << m;
    go_idle(m);
    for (int i = 1; i <= n; i++)
      cyc(1'b1, (i == 1) ? NSQ : SQ, INCR, 1'b1, (i % len) == 0, req);
  endtask

  task automatic t_unlimited();
    go_idle(3'd0);
    for (int i = 1; i <= 300; i++)
      cyc(1'b1, (i == 1) ? NSQ : SQ, INCR, 1'b1, 1'b0, "R2");
  endtask

  task automatic t_single();
    go_idle(3'd1);
    for (int i = 1; i <= 6; i++)
      cyc(1'b1, (i == 1) ? NSQ : SQ, INCR, 1'b1, 1'b1, "R3");
  endtask

  task automatic t_waits();
    go_idle(3'd2);
    cyc(1'b1, NSQ, INCR, 1'b1, 1'b0, "R4");
    cyc(1'b1, SQ, INCR, 1'b0, 1'b0, "R4");
    cyc(1'b1, SQ, INCR, 1'b1, 1'b0, "R4");
    cyc(1'b0, SQ, INCR, 1'b1, 1'b0, "R4");
    cyc(1'b1, SQ, INCR, 1'b1, 1'b0, "R4");
    cyc(1'b1, SQ, INCR, 1'b0, 1'b0, "R4");
    cyc(1'b1, SQ, INCR, 1'b1, 1'b1, "R4");
  endtask

  task automatic t_busy();
    go_idle(3'd2);
    cyc(1'b1, NSQ, INCR, 1'b1, 1'b0, "R5");
    cyc(1'b1, SQ, INCR, 1'b1, 1'b0, "R5");
    cyc(1'b1, BSY, INCR, 1'b1, 1'b0, "R5");
    cyc(1'b1, BSY, INCR, 1'b1, 1'b0, "R5");
    cyc(1'b1, SQ, INCR, 1'b1, 1'b0, "R5");
    cyc(1'b1, SQ, INCR, 1'b1, 1'b1, "R5");
  endtask

  task automatic t_idle_clear();
    go_idle(3'd2);
    cyc(1'b1, NSQ, INCR, 1'b1, 1'b0, "R6");
    cyc(1'b1, SQ, INCR, 1'b1, 1'b0, "R6");
    cyc(1'b1, SQ, INCR, 1'b1, 1'b0, "R6");
    cyc(1'b1, IDL, 3'b000, 1'b1, 1'b0, "R6");
    cyc(1'b1, NSQ, INCR, 1'b1, 1'b0, "R6");
    cyc(1'b1, SQ, INCR, 1'b1, 1'b0, "R6");
    cyc(1'b1, SQ, INCR, 1'b1, 1'b0, "R6");
    cyc(1'b1, SQ, INCR, 1'b1, 1'b1, "R6");
  endtask

  task automatic t_restart();
    go_idle(3'd2);
    cyc(1'b1, NSQ, INCR, 1'b1, 1'b0, "R7");
    cyc(1'b1, SQ, INCR, 1'b1, 1'b0, "R7");
    cyc(1'b1, SQ, INCR, 1'b1, 1'b0, "R7");
    for (int i = 1; i <= 4; i++)
      cyc(1'b1, (i == 1) ? NSQ : SQ, INCR, 1'b1, i == 4, "R7");
  endtask

  task automatic t_fixed();
    go_idle(3'd1);
    for (int i = 1; i <= 4; i++)
      cyc(1'b1, (i == 1) ? NSQ : SQ, INCR4, 1'b1, 1'b0, "R8");
    go_idle(3'd2);
    for (int i = 1; i <= 8; i++)
      cyc(1'b1, (i == 1) ? NSQ : SQ, 3'b000 + 3'(i == 1 ? 5 : 5), 1'b1, 1'b0, "R8");
  endtask

  initial begin
    #30000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_chunks(3'd2, 12, "R10");
    for (int m = 2; m <= 7; m++)
      t_chunks(3'(m), 2 * (1 << m) + 3, "R1");
    t_unlimited();
    t_single();
    t_waits();
    t_busy();
    t_idle_clear();
    t_restart();
    t_chunks(3'd3, 24, "R9");
    t_fixed();
    go_idle(3'd0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule